// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block is a bank of chip-level control registers on a single-cycle register bus. Each access carries a byte address and, for writes, a write strobe and 32 bits of data. Read data is combinational from the current address, so a read completes in the same cycle. Write effects appear after the next rising clock edge.

Every writable register in the bank is behind a global two-step unlock. Software writes a first key to one unlock register and then a second key to another. A wrong value, or a step taken out of order, drops the bank back to locked.

On top of that global gate, the bank has three finer protections:
- One configuration register also needs a matching key held in its own lock register.
- One register takes only its first accepted write.
- One register lets each bit be committed once, independently of the others.

The bank also presents a read-only device status word, a read-only silicon revision field, a privilege word with a non-zero reset value, and a single Ethernet RMII reset control bit. The stored values leave the block as output ports and drive the surrounding logic.

Top module: `cfg_keybank`

## Requirements
- R1: After synchronous reset the bank is locked (bit 0 of a read at 0x38 is 0), the per-bit register at 0x104 reads 0, the write-once register at 0x100 reads 0 and the write-once flags are clear.
- R2: Writing 0x83E70B13 to 0x38 and then 0x95A4F1E0 to 0x3C opens the bank. While the bank is open, a read at 0x38 returns 1 and a read at 0x3C returns 0.
- R3: A write to 0x38 with a value other than its key locks the bank. A write to 0x3C locks the bank unless it carries its key and immediately follows the correct first step with no other unlock write in between. From the open state, writing the correct first key to 0x38 again also locks the bank.
- R4: While the bank is locked, writes to any register other than 0x38/0x3C are dropped, and their read data stays unchanged.
- R5: The register at 0x40008 accepts a write only when the bank is open and the lock register at 0x40004 holds 0x0F0A0B00. The value is driven on `lcfg_o`.
- R6: The register at 0x100 stores the first write accepted while the bank is open and ignores all later writes until reset. Writes dropped while the bank is locked do not use up its single write.
- R7: A write to 0x104 works bit by bit:
  - bits [31:16] select bits and bits [15:0] carry their values;
  - a selected bit whose written flag is clear takes the value, and its flag sets;
  - a bit whose flag is already set keeps its value.
  
  A read returns flags in [31:16] and values in [15:0]. The values are driven on `wbits_o`.
- R8: A read at 0x8 returns the revision parameter in bits [31:28] and zero elsewhere. Writes to 0x8 have no effect.
- R9: A read at 0x0 returns `dev_status_i`, and writes to 0x0 have no effect.
- R10: At 0x40020 only bit 18 (mask 0x00040000) is stored, and it drives `rmii_rst_o`. The other bits read as 0.
- R11: The privilege register at 0x41C resets to 0xAAAAAAAA and is writable while the bank is open. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 20 | Byte address |
| wdata | input | 32 | Write data |
| dev_status_i | input | 32 | Device status word presented for reading |
| rdata | output | 32 | Read data for the current address |
| kick_open_o | output | 1 | Bank is unlocked |
| lcfg_o | output | 32 | Key-locked configuration value |
| priv_o | output | 32 | Privilege word |
| rmii_rst_o | output | 1 | RMII reset control |
| wonce_o | output | 32 | Write-once register value |
| wbits_o | output | WB_N | Per-bit write-once values |

## Verification
The bench first tries the unlock in the wrong order and with wrong second keys. A state machine that skipped the ordering check would open the bank on the second key alone.

It also re-locks an open bank with a wrong key and then writes to the privilege register. A design that latched "open" would accept that write.

The key-locked register is written three ways: with the lock clear, with the key present, and with the key off by one bit. A design that ignored the lock, or compared only part of it, would store a value it should drop.

The write-once register is first written while the bank is locked, and the per-bit register is hit with overlapping selections. A design that used up the single write on a dropped access, or that let a committed bit be rewritten, would read back a wrong value. A second reset must clear every written flag.

// File: rtl/cfg_keybank_pkg.sv
package cfg_keybank_pkg;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_STAT  = 20'h00000;
    localparam logic [ADDR_W-1:0] OFF_REV   = 20'h00008;
    localparam logic [ADDR_W-1:0] OFF_KICK0 = 20'h00038;
    localparam logic [ADDR_W-1:0] OFF_KICK1 = 20'h0003C;
    localparam logic [ADDR_W-1:0] OFF_WONCE = 20'h00100;
    localparam logic [ADDR_W-1:0] OFF_WBITS = 20'h00104;
    localparam logic [ADDR_W-1:0] OFF_PRIV  = 20'h0041C;
    localparam logic [ADDR_W-1:0] OFF_LOCK  = 20'h40004;
    localparam logic [ADDR_W-1:0] OFF_LCFG  = 20'h40008;
    localparam logic [ADDR_W-1:0] OFF_RMII  = 20'h40020;

    localparam logic [DATA_W-1:0] KICK_KEY0 = 32'h83E70B13;
    localparam logic [DATA_W-1:0] KICK_KEY1 = 32'h95A4F1E0;
    localparam logic [DATA_W-1:0] LOCK_KEY  = 32'h0F0A0B00;
    localparam logic [DATA_W-1:0] PRIV_RST  = 32'hAAAAAAAA;
    localparam int                RMII_BIT  = 18;
    localparam int                REV_LSB   = 28;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } kick_st_e;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_STAT, SEL_REV, SEL_KICK0, SEL_KICK1, SEL_WONCE,
        SEL_WBITS, SEL_PRIV, SEL_LOCK, SEL_LCFG, SEL_RMII
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] lock;
        logic [DATA_W-1:0] lcfg;
        logic [DATA_W-1:0] priv;
        logic [DATA_W-1:0] wonce;
        logic              wonce_done;
        logic              rmii;
    } bank_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        s = SEL_NONE;
        if (a == OFF_STAT)       s = SEL_STAT;
        else if (a == OFF_REV)   s = SEL_REV;
        else if (a == OFF_KICK0) s = SEL_KICK0;
        else if (a == OFF_KICK1) s = SEL_KICK1;
        else if (a == OFF_WONCE) s = SEL_WONCE;
        else if (a == OFF_WBITS) s = SEL_WBITS;
        else if (a == OFF_PRIV)  s = SEL_PRIV;
        else if (a == OFF_LOCK)  s = SEL_LOCK;
        else if (a == OFF_LCFG)  s = SEL_LCFG;
        else if (a == OFF_RMII)  s = SEL_RMII;
        return s;
    endfunction

endpackage

// File: rtl/cfg_kick_fsm.sv
module cfg_kick_fsm
    import cfg_keybank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic              open_o
);

    kick_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (wr_en && sel == SEL_KICK0) begin
            st_d = (wdata == KICK_KEY0) ? KS_HALF : KS_LOCKED;
        end else if (wr_en && sel == SEL_KICK1) begin
            st_d = (wdata == KICK_KEY1 && st_q == KS_HALF) ? KS_OPEN : KS_LOCKED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= KS_LOCKED;
        else     st_q <= st_d;
    end

    assign open_o = (st_q == KS_OPEN);

    // R2
    kick_open_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(open_o) |-> $past(wr_en && sel == SEL_KICK1 && wdata == KICK_KEY1));

    // R3
    kick_bad_relock_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_KICK0 && wdata != KICK_KEY0) |=> !open_o);

    // R3
    kick_bad_second_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_KICK1 && wdata != KICK_KEY1) |=> !open_o);

endmodule

// File: rtl/cfg_wonce_bits.sv
module cfg_wonce_bits #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [N-1:0] sel,
    input  logic [N-1:0] val,
    output logic [N-1:0] q_o,
    output logic [N-1:0] flag_o
);

    logic [N-1:0] val_q;
    logic [N-1:0] flag_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                val_q[i]  <= 1'b0;
                flag_q[i] <= 1'b0;
            end else if (we && sel[i] && !flag_q[i]) begin
                val_q[i]  <= val[i];
                flag_q[i] <= 1'b1;
            end
        end

        // R7
        wbit_hold_chk: assert property (@(posedge clk) disable iff (rst)
            flag_q[i] |=> $stable(val_q[i]));

        // R7
        wbit_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            flag_q[i] |=> flag_q[i]);
    end

    assign q_o    = val_q;
    assign flag_o = flag_q;

endmodule

// File: rtl/cfg_keybank.sv
module cfg_keybank
    import cfg_keybank_pkg::*;
#(
    parameter int         WB_N        = 16,
    parameter logic [3:0] SILICON_REV = 4'h3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] dev_status_i,
    output logic [DATA_W-1:0] rdata,
    output logic              kick_open_o,
    output logic [DATA_W-1:0] lcfg_o,
    output logic [DATA_W-1:0] priv_o,
    output logic              rmii_rst_o,
    output logic [DATA_W-1:0] wonce_o,
    output logic [WB_N-1:0]   wbits_o
);

    localparam int HALF_W = DATA_W / 2;

    reg_sel_e           sel;
    logic               open;
    logic               wr_ok;
    logic               lock_match;
    bank_t              bank_q;
    logic [WB_N-1:0]    wb_val;
    logic [WB_N-1:0]    wb_flag;

    assign sel        = decode_addr(addr);
    assign wr_ok      = wr_en && open;
    assign lock_match = (bank_q.lock == LOCK_KEY);

    cfg_kick_fsm u_kick (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .sel    (sel),
        .wdata  (wdata),
        .open_o (open)
    );

    cfg_wonce_bits #(.N(WB_N)) u_wbits (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_ok && sel == SEL_WBITS),
        .sel    (wdata[HALF_W +: WB_N]),
        .val    (wdata[WB_N-1:0]),
        .q_o    (wb_val),
        .flag_o (wb_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q.lock       <= '0;
            bank_q.lcfg       <= '0;
            bank_q.priv       <= PRIV_RST;
            bank_q.wonce      <= '0;
            bank_q.wonce_done <= 1'b0;
            bank_q.rmii       <= 1'b0;
        end else if (wr_ok) begin
            case (sel)
                SEL_LOCK: bank_q.lock <= wdata;
                SEL_LCFG: if (lock_match) bank_q.lcfg <= wdata;
                SEL_PRIV: bank_q.priv <= wdata;
                SEL_RMII: bank_q.rmii <= wdata[RMII_BIT];
                SEL_WONCE: if (!bank_q.wonce_done) begin
                    bank_q.wonce      <= wdata;
                    bank_q.wonce_done <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_STAT:  rdata = dev_status_i;
            SEL_REV:   rdata[REV_LSB +: 4] = SILICON_REV;
            SEL_KICK0: rdata[0] = open;
            SEL_WONCE: rdata = bank_q.wonce;
            SEL_WBITS: begin
                rdata[WB_N-1:0]       = wb_val;
                rdata[HALF_W +: WB_N] = wb_flag;
            end
            SEL_PRIV:  rdata = bank_q.priv;
            SEL_LOCK:  rdata = bank_q.lock;
            SEL_LCFG:  rdata = bank_q.lcfg;
            SEL_RMII:  rdata[RMII_BIT] = bank_q.rmii;
            default:   rdata = '0;
        endcase
    end

    assign kick_open_o = open;
    assign lcfg_o      = bank_q.lcfg;
    assign priv_o      = bank_q.priv;
    assign rmii_rst_o  = bank_q.rmii;
    assign wonce_o     = bank_q.wonce;
    assign wbits_o     = wb_val;

    // R4
    priv_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !open) |=> ($stable(bank_q.priv) && $stable(bank_q.lock) && $stable(bank_q.rmii)));

    // R5
    lcfg_key_chk: assert property (@(posedge clk) disable iff (rst)
        (!lock_match || !open) |=> $stable(bank_q.lcfg));

    // R6
    wonce_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bank_q.wonce_done |=> ($stable(bank_q.wonce) && bank_q.wonce_done));

    // R8
    rev_field_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_REV) |-> (rdata[REV_LSB +: 4] == SILICON_REV && rdata[REV_LSB-1:0] == '0));

endmodule

// File: tb/cfg_keybank_tb.sv
module cfg_keybank_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [19:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] dev_status = '0;
    logic [31:0] rdata;
    logic        kick_open;
    logic [31:0] lcfg;
    logic [31:0] priv;
    logic        rmii_rst;
    logic [31:0] wonce;
    logic [15:0] wbits;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cfg_keybank u_dut (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .addr         (addr),
        .wdata        (wdata),
        .dev_status_i (dev_status),
        .rdata        (rdata),
        .kick_open_o  (kick_open),
        .lcfg_o       (lcfg),
        .priv_o       (priv),
        .rmii_rst_o   (rmii_rst),
        .wonce_o      (wonce),
        .wbits_o      (wbits)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [19:0] a, input logic [31:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [19:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic unlock();
        wr(20'h00038, 32'h83E70B13);
        wr(20'h0003C, 32'h95A4F1E0);
    endtask

    task automatic t_reset();
        rd_chk("R1 kick locked", 20'h00038, 32'h0);
        rd_chk("R1 wbits clear", 20'h00104, 32'h0);
        rd_chk("R1 wonce clear", 20'h00100, 32'h0);
        rd_chk("R11 priv reset", 20'h0041C, 32'hAAAAAAAA);
    endtask

    task automatic t_locked_drop();
        wr(20'h0041C, 32'h12345678);
        rd_chk("R4 priv dropped", 20'h0041C, 32'hAAAAAAAA);
        wr(20'h40004, 32'h0F0A0B00);
        rd_chk("R4 lock dropped", 20'h40004, 32'h0);
        wr(20'h00100, 32'h00000055);
        rd_chk("R4 wonce dropped", 20'h00100, 32'h0);
        wr(20'h40020, 32'hFFFFFFFF);
        rd_chk("R4 rmii dropped", 20'h40020, 32'h0);
    endtask

    task automatic t_bad_kick();
        wr(20'h0003C, 32'h95A4F1E0);
        rd_chk("R3 second key alone", 20'h00038, 32'h0);
        wr(20'h00038, 32'h83E70B13);
        wr(20'h0003C, 32'h95A4F1E1);
        rd_chk("R3 wrong second key", 20'h00038, 32'h0);
        wr(20'h00038, 32'h83E70B13);
        wr(20'h00038, 32'h00000000);
        wr(20'h0003C, 32'h95A4F1E0);
        rd_chk("R3 first step undone", 20'h00038, 32'h0);
    endtask

    task automatic t_unlock();
        unlock();
        rd_chk("R2 open", 20'h00038, 32'h1);
        rd_chk("R2 kick1 reads 0", 20'h0003C, 32'h0);
        check("R2 open port", {31'b0, kick_open}, 32'h1);
        wr(20'h0041C, 32'h00001111);
        rd_chk("R11 priv write", 20'h0041C, 32'h00001111);
        wr(20'h00038, 32'h00000000);
        rd_chk("R3 relock", 20'h00038, 32'h0);
        wr(20'h0041C, 32'h00002222);
        rd_chk("R3 write after relock", 20'h0041C, 32'h00001111);
        unlock();
        wr(20'h00038, 32'h83E70B13);
        rd_chk("R3 first key from open", 20'h00038, 32'h0);
    endtask

    task automatic t_lockreg();
        unlock();
        wr(20'h40008, 32'h0000DEAD);
        rd_chk("R5 lock clear", 20'h40008, 32'h0);
        wr(20'h40004, 32'h0F0A0B00);
        wr(20'h40008, 32'hCAFE0001);
        rd_chk("R5 keyed write", 20'h40008, 32'hCAFE0001);
        check("R5 lcfg port", lcfg, 32'hCAFE0001);
        wr(20'h40004, 32'h0F0A0B01);
        wr(20'h40008, 32'h00000005);
        rd_chk("R5 near key", 20'h40008, 32'hCAFE0001);
    endtask

    task automatic t_wonce();
        wr(20'h00100, 32'h0000A5A5);
        rd_chk("R6 first write", 20'h00100, 32'h0000A5A5);
        wr(20'h00100, 32'h00001234);
        rd_chk("R6 second ignored", 20'h00100, 32'h0000A5A5);
        check("R6 port", wonce, 32'h0000A5A5);
    endtask

    task automatic t_wbits();
        wr(20'h00104, 32'h00030001);
        rd_chk("R7 first select", 20'h00104, 32'h00030001);
        wr(20'h00104, 32'h00060006);
        rd_chk("R7 overlap", 20'h00104, 32'h00070005);
        wr(20'h00104, 32'hFFFF0000);
        rd_chk("R7 all select", 20'h00104, 32'hFFFF0005);
        wr(20'h00104, 32'hFFFFFFFF);
        rd_chk("R7 all committed", 20'h00104, 32'hFFFF0005);
        check("R7 port", {16'b0, wbits}, 32'h00000005);
    endtask

    task automatic t_ro();
        rd_chk("R8 rev", 20'h00008, 32'h30000000);
        wr(20'h00008, 32'hFFFFFFFF);
        rd_chk("R8 rev write", 20'h00008, 32'h30000000);
        dev_status = 32'h13572468;
        rd_chk("R9 status", 20'h00000, 32'h13572468);
        wr(20'h00000, 32'h0);
        rd_chk("R9 status write", 20'h00000, 32'h13572468);
        rd_chk("R11 unmapped", 20'h00200, 32'h0);
    endtask

    task automatic t_rmii();
        wr(20'h40020, 32'hFFFFFFFF);
        rd_chk("R10 rmii set", 20'h40020, 32'h00040000);
        check("R10 port", {31'b0, rmii_rst}, 32'h1);
        wr(20'h40020, 32'hFFFBFFFF);
        rd_chk("R10 rmii clear", 20'h40020, 32'h0);
    endtask

    task automatic t_reset_again();
        do_reset();
        rd_chk("R1 wbits after reset", 20'h00104, 32'h0);
        rd_chk("R1 kick after reset", 20'h00038, 32'h0);
        unlock();
        wr(20'h00100, 32'h00000077);
        rd_chk("R1 wonce flag cleared", 20'h00100, 32'h00000077);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_locked_drop();
        t_bad_kick();
        t_unlock();
        t_lockreg();
        t_wonce();
        t_wbits();
        t_ro();
        t_rmii();
        t_reset_again();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule